// File: doc/BRIEF.md
# Page Half-Line Swap Engine

This block repairs the byte layout of memory pages after they have moved to new physical locations. Some memory controllers decide which channel serves an access by folding a high physical address bit, bit 17, into the address. A page whose bit 17 changes while it is away from memory therefore comes back with each 64-byte unit sitting in the slot of its neighbour. The engine walks a list of 4 KiB pages and finds every page whose current physical bit 17 differs from the value saved when the page was last recorded. For each such page it exchanges the lower and upper 64-byte halves of every 128-byte block, then reports that page as dirty.

A companion save operation walks the same list and writes each page's current bit 17 into an internal per-page record. A restore that runs before any save has ever been made leaves memory alone. Software or a sequencer starts an operation with a one-cycle start pulse, giving the operation type and the page count. The engine then presents each page index in turn and samples the physical address returned for it. It drives a word-addressed 32-bit memory port and ends the operation with a one-cycle done pulse.

Top module: `half_swap_engine`

## Requirements
- R1: After reset, busy, done, dirty and the memory write and read enables are all low, and no bit-17 record exists.
- R2: Swapping a page exchanges, for every 32-word (128-byte) block, word k of the lower 16 words with word k of the upper 16 words. Within a 1024-word page, every word at offset o ends up holding the old value from offset o XOR 16. The page's memory word address is {phys[MEM_AW+1:12], offset}.
- R3: A restore swaps page i only when bit 17 of that page's current physical address differs from the recorded bit for index i. Any other page is left unchanged in memory.
- R4: Each swapped page gives exactly one dirty pulse, with the dirty index output equal to the page index. A page that is not swapped gives no dirty pulse.
- R5: A save sets the record bit of page i when bit 17 of its physical address is 1 and clears it when that bit is 0. A save never writes memory.
- R6: A restore issued while no record exists since reset writes no memory, gives no dirty pulse, and still finishes with done.
- R7: Pages are handled in ascending index order, starting at 0 and ending at count-1, so dirty pulses come out in ascending index order.
- R8: Done is high for exactly one cycle once the last page is finished. Busy is high from the cycle after start is accepted up to and including the done cycle.
- R9: A start pulse that arrives while busy is high is ignored, and the running operation's result is unchanged.
- R10: A page count of zero finishes at once: done is high in the first cycle after start is accepted, and nothing else happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| save_i | input | 1 | Operation type, sampled with start: 1 = save bits, 0 = restore layout |
| page_count_i | input | CNT_W | Number of pages in the list, sampled with start |
| page_idx_o | output | IDX_W | Index of the page being looked up |
| page_phys_i | input | PHYS_W | Physical byte address of page page_idx_o, page aligned, valid in the same cycle |
| mem_addr_o | output | MEM_AW | Word address of the memory port |
| mem_re_o | output | 1 | Read enable; data returns on mem_rdata_i one cycle later |
| mem_we_o | output | 1 | Write enable |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after mem_re_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dirty_o | output | 1 | One-cycle pulse: a page is being swapped |
| dirty_idx_o | output | IDX_W | Index of the page flagged by dirty_o |

## Verification
The bench builds the engine with MEM_AW = 12 and MAX_PAGES = 8, and keeps the page size at 4 KiB and the watched bit at 17. The memory behind the port is then only four page slots (16 KiB), because it decodes only the low address bits. Physical addresses can still set or clear bit 17 freely, so a single slot can be presented as a page that moved across the bit-17 boundary. This makes every mix of recorded and current bits reachable within a few thousand cycles per operation, and the bench compares the whole memory against a model after each operation. It also covers a list shorter than the filled page table, a count of zero, and a start pulse that arrives in the middle of a swap.

// File: rtl/half_swap_pkg.sv
// Shared types for the page half-line swap engine.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package half_swap_pkg;

    // Sequencer states of the engine
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,   // waiting for start
        S_PAGE  = 3'd1,   // evaluate one page of the list
        S_RD_A  = 3'd2,   // read lower half of a block into the buffer
        S_SW_RD = 3'd3,   // read one word of the upper half
        S_SW_WA = 3'd4,   // write that word into the lower half
        S_SW_WB = 3'd5,   // write buffered lower word into the upper half
        S_FIN   = 3'd6    // done pulse
    } swap_state_t;

endpackage

// File: rtl/swap_half_buffer.sv
// Holds one 64-byte half-block while its partner half is copied over it.
// One synchronous write port, one combinational read port.
// Assumes: the controller never reads an entry in the same cycle it writes it.
module swap_half_buffer #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] store_q [DEPTH];

    // Capture one returning word into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else if (wr_en_i) begin
            store_q[wr_idx_i] <= wr_data_i;
        end
    end

    // Present the slot the controller asks for
    assign rd_data_o = store_q[rd_idx_i];

endmodule

// File: rtl/swap_bit_record.sv
// Per-page record of the saved address bit, plus a flag that says whether
// any record has been taken since reset.
// Assumes: arm_i is raised when a save operation is accepted, before its writes.
module swap_bit_record #(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic          wr_bit_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic          rd_bit_o,
    output logic          valid_o
);

    logic [DEPTH-1:0] bits_q;
    logic             valid_q;

    // Record exists once any save has been accepted
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= 1'b0;
        else if (arm_i) valid_q <= 1'b1;
    end

    // Set or clear one page's bit
    always_ff @(posedge clk) begin
        if (!rst_n)       bits_q <= '0;
        else if (wr_en_i) bits_q[wr_idx_i] <= wr_bit_i;
    end

    assign rd_bit_o = bits_q[rd_idx_i];
    assign valid_o  = valid_q;

    // A bit is only written while a save is armed
    AST_REC_WRITE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> valid_q);  // R5

endmodule

// File: rtl/half_swap_engine.sv
// Page half-line swap engine.
// Save: walks page_count pages and records bit FLAG_BIT of each page's
// physical address. Restore: for every page whose current bit differs from
// the record, exchanges the two halves of each block and pulses dirty.
// Assumes: page_phys_i is page aligned and valid in the cycle page_idx_o
// shows its index; memory reads return data one cycle after mem_re_o.
module half_swap_engine
    import half_swap_pkg::*;
#(
    parameter int PHYS_W      = 32,
    parameter int MEM_AW      = 16,
    parameter int MAX_PAGES   = 64,
    parameter int PAGE_BYTES  = 4096,
    parameter int BLOCK_BYTES = 128,
    parameter int FLAG_BIT    = 17,
    localparam int WORD_BYTES = 4,
    localparam int CNT_W      = $clog2(MAX_PAGES + 1),
    localparam int IDX_W      = $clog2(MAX_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              save_i,
    input  logic [CNT_W-1:0]  page_count_i,
    output logic [IDX_W-1:0]  page_idx_o,
    input  logic [PHYS_W-1:0] page_phys_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              dirty_o,
    output logic [IDX_W-1:0]  dirty_idx_o
);

    localparam int HALF_WORDS = BLOCK_BYTES / 2 / WORD_BYTES;
    localparam int BLOCKS     = PAGE_BYTES / BLOCK_BYTES;
    localparam int K_W        = $clog2(HALF_WORDS);
    localparam int BLK_W      = $clog2(BLOCKS);
    localparam int OFF_W      = BLK_W + 1 + K_W;
    localparam int PAGE_SH    = $clog2(PAGE_BYTES);
    localparam int SLOT_W     = MEM_AW - OFF_W;

    swap_state_t           state_q;
    logic                  save_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      idx_q;
    logic [SLOT_W-1:0]     slot_q;
    logic [BLK_W-1:0]      blk_q;
    logic [K_W-1:0]        k_q;
    logic                  cap_v_q;
    logic [K_W-1:0]        cap_k_q;
    logic                  dirty_q;
    logic [IDX_W-1:0]      dirty_idx_q;

    logic                  rec_bit;
    logic                  rec_valid;
    logic [31:0]           buf_rd;
    logic                  cur_bit;
    logic                  last_page;
    logic                  last_word;
    logic                  last_blk;
    logic                  mismatch;
    logic                  accept;
    logic                  upper_half;

    assign cur_bit    = page_phys_i[FLAG_BIT];
    assign last_page  = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));
    assign last_word  = (k_q == K_W'(HALF_WORDS - 1));
    assign last_blk   = (blk_q == BLK_W'(BLOCKS - 1));
    assign mismatch   = (cur_bit != rec_bit);
    assign accept     = (state_q == S_IDLE) && start_i;
    assign upper_half = (state_q == S_SW_RD) || (state_q == S_SW_WB);

    // Saved-bit record, armed by an accepted save
    swap_bit_record #(.DEPTH(MAX_PAGES)) i_record (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (accept && save_i),
        .wr_en_i  ((state_q == S_PAGE) && save_q),
        .wr_idx_i (idx_q),
        .wr_bit_i (cur_bit),
        .rd_idx_i (idx_q),
        .rd_bit_o (rec_bit),
        .valid_o  (rec_valid)
    );

    // Temporary copy of one lower half-block
    swap_half_buffer #(.WIDTH(32), .DEPTH(HALF_WORDS)) i_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cap_v_q),
        .wr_idx_i  (cap_k_q),
        .wr_data_i (mem_rdata_i),
        .rd_idx_i  (k_q),
        .rd_data_o (buf_rd)
    );

    // Read-return tracking: data of a lower-half read lands one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v_q <= 1'b0;
            cap_k_q <= '0;
        end else begin
            cap_v_q <= (state_q == S_RD_A);
            cap_k_q <= k_q;
        end
    end

    // Main sequencer: page walk, block walk, word walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            save_q      <= 1'b0;
            cnt_q       <= '0;
            idx_q       <= '0;
            slot_q      <= '0;
            blk_q       <= '0;
            k_q         <= '0;
            dirty_q     <= 1'b0;
            dirty_idx_q <= '0;
        end else begin
            dirty_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        save_q <= save_i;
                        cnt_q  <= page_count_i;
                        idx_q  <= '0;
                        if (page_count_i == '0 || (!save_i && !rec_valid))
                            state_q <= S_FIN;
                        else
                            state_q <= S_PAGE;
                    end
                end
                S_PAGE: begin
                    if (!save_q && mismatch) begin
                        dirty_q     <= 1'b1;
                        dirty_idx_q <= idx_q;
                        slot_q      <= page_phys_i[MEM_AW+1:PAGE_SH];
                        blk_q       <= '0;
                        k_q         <= '0;
                        state_q     <= S_RD_A;
                    end else if (last_page) begin
                        state_q <= S_FIN;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                S_RD_A: begin
                    if (last_word) begin
                        k_q     <= '0;
                        state_q <= S_SW_RD;
                    end else begin
                        k_q <= k_q + K_W'(1);
                    end
                end
                S_SW_RD: state_q <= S_SW_WA;
                S_SW_WA: state_q <= S_SW_WB;
                S_SW_WB: begin
                    if (!last_word) begin
                        k_q     <= k_q + K_W'(1);
                        state_q <= S_SW_RD;
                    end else begin
                        k_q <= '0;
                        if (!last_blk) begin
                            blk_q   <= blk_q + BLK_W'(1);
                            state_q <= S_RD_A;
                        end else if (last_page) begin
                            state_q <= S_FIN;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= S_PAGE;
                        end
                    end
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Memory port decode from the current walk position
    always_comb begin
        mem_addr_o  = {slot_q, blk_q, upper_half, k_q};
        mem_re_o    = (state_q == S_RD_A) || (state_q == S_SW_RD);
        mem_we_o    = (state_q == S_SW_WA) || (state_q == S_SW_WB);
        mem_wdata_o = (state_q == S_SW_WA) ? mem_rdata_i : buf_rd;
    end

    assign page_idx_o  = idx_q;
    assign busy_o      = (state_q != S_IDLE);
    assign done_o      = (state_q == S_FIN);
    assign dirty_o     = dirty_q;
    assign dirty_idx_o = dirty_idx_q;

    // Done never lasts longer than one cycle
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R8

    // Page index only ever steps up by one during an operation
    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(idx_q)) |-> (idx_q == $past(idx_q) + IDX_W'(1)));  // R7

    // Dirty pulses only come from a restore
    AST_DIRTY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_o |-> (busy_o && !save_q));  // R4

    // A swap never starts without a record
    AST_SWAP_HAS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dirty_o) |-> rec_valid);  // R6

    // No memory write outside a swap of a restore
    AST_WRITE_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (!save_q && !done_o));  // R5

    // A start while busy does not reload the page count
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(cnt_q));  // R9

    // A zero count goes straight to done
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && page_count_i == '0) |=> done_o);  // R10

endmodule

// File: tb/test_half_swap_engine.sv
// Directed bench for the page half-line swap engine.
module test_half_swap_engine;

    localparam int MEM_AW = 12;
    localparam int MAXP   = 8;
    localparam int CNT_W  = $clog2(MAXP + 1);
    localparam int IDX_W  = $clog2(MAXP);
    localparam int WORDS  = 1 << MEM_AW;
    localparam int BIT17  = 32'h0002_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              save_i = 1'b0;
    logic [CNT_W-1:0]  page_count_i = '0;
    logic [IDX_W-1:0]  page_idx_o;
    logic [31:0]       page_phys_i;
    logic [MEM_AW-1:0] mem_addr_o;
    logic              mem_re_o, mem_we_o;
    logic [31:0]       mem_wdata_o;
    logic [31:0]       mem_rdata_i;
    logic              busy_o, done_o, dirty_o;
    logic [IDX_W-1:0]  dirty_idx_o;

    logic [31:0] mem [WORDS];
    logic [31:0] exp_mem [WORDS];
    logic [31:0] phys_tab [MAXP];
    logic        init_mem = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    half_swap_engine #(.MEM_AW(MEM_AW), .MAX_PAGES(MAXP)) i_half_swap_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .save_i(save_i),
        .page_count_i(page_count_i), .page_idx_o(page_idx_o),
        .page_phys_i(page_phys_i), .mem_addr_o(mem_addr_o),
        .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .dirty_o(dirty_o), .dirty_idx_o(dirty_idx_o)
    );

    assign page_phys_i = phys_tab[page_idx_o];

    function automatic logic [31:0] pattern(input int i);
        return (32'(i) * 32'h0001_0003) ^ 32'hA5C3_0000;
    endfunction

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (init_mem) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= pattern(i);
        end else begin
            if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
            if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Expected effect of swapping the page in memory slot s
    task automatic model_swap(input int s);
        logic [31:0] tmp [1024];
        for (int o = 0; o < 1024; o++) tmp[o] = exp_mem[s*1024 + (o ^ 16)];
        for (int o = 0; o < 1024; o++) exp_mem[s*1024 + o] = tmp[o];
    endtask

    task automatic check_mem(input string req);
        int bad = 0;
        for (int i = 0; i < WORDS; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    // Run one operation; returns dirty indices, latency, extra done count
    task automatic run_op(input logic save, input int cnt, input bit poke,
                          output int nd, output int dl[8], output int lat,
                          output int dones, output int busy_gap);
        int cyc = 0;
        bit seen = 0;
        nd = 0; dones = 0; busy_gap = 0; lat = -1;
        for (int j = 0; j < 8; j++) dl[j] = -1;
        @(negedge clk);
        start_i = 1'b1; save_i = save; page_count_i = CNT_W'(cnt);
        while (!seen) begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
            if (poke && cyc == 40) begin
                start_i = 1'b1; save_i = 1'b1; page_count_i = '0;
            end
            if (dirty_o) begin
                if (nd < 8) dl[nd] = int'(dirty_idx_o);
                nd++;
            end
            if (!busy_o) busy_gap++;
            if (done_o) begin seen = 1; lat = cyc; dones++; end
            if (cyc > 30000) begin
                check(0, "watchdog", cyc, 30000);
                seen = 1;
            end
        end
        start_i = 1'b0;
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            if (done_o) dones++;
            if (busy_o) busy_gap++;
        end
    endtask

    task automatic t_reset;
        check(busy_o == 0 && done_o == 0 && dirty_o == 0, "R1 outputs", int'({busy_o, done_o, dirty_o}), 0);
        check(mem_we_o == 0 && mem_re_o == 0, "R1 mem enables", int'({mem_we_o, mem_re_o}), 0);
    endtask

    task automatic t_no_record;
        int nd, lat, dn, bg; int dl[8];
        for (int p = 0; p < 4; p++) phys_tab[p] = 32'(p << 12) | BIT17;
        run_op(1'b0, 4, 0, nd, dl, lat, dn, bg);
        check(nd == 0, "R6 no dirty without record", nd, 0);
        check(dn == 1, "R6 done without record", dn, 1);
        check_mem("R6 memory untouched");
    endtask

    task automatic t_zero;
        int nd, lat, dn, bg; int dl[8];
        run_op(1'b0, 0, 0, nd, dl, lat, dn, bg);
        check(lat == 1, "R10 done latency", lat, 1);
        check(dn == 1, "R10 single done", dn, 1);
        check(nd == 0, "R10 no dirty", nd, 0);
    endtask

    task automatic t_save_match;
        int nd, lat, dn, bg; int dl[8];
        phys_tab[0] = 32'h0000_0000 | BIT17;
        phys_tab[1] = 32'h0000_1000;
        phys_tab[2] = 32'h0000_2000 | BIT17;
        phys_tab[3] = 32'h0000_3000;
        run_op(1'b1, 4, 0, nd, dl, lat, dn, bg);
        check(nd == 0, "R5 save gives no dirty", nd, 0);
        check_mem("R5 save leaves memory");
        check(dn == 1 && bg == 0, "R8 save done once busy throughout", dn, 1);
        run_op(1'b0, 4, 0, nd, dl, lat, dn, bg);
        check(nd == 0, "R3 matching bits no swap", nd, 0);
        check_mem("R3 memory unchanged on match");
    endtask

    task automatic t_swap;
        int nd, lat, dn, bg; int dl[8];
        phys_tab[1] = 32'h0000_1000 | BIT17;   // recorded 0, now 1
        phys_tab[2] = 32'h0000_2000;           // recorded 1, now 0
        model_swap(1);
        model_swap(2);
        run_op(1'b0, 4, 1, nd, dl, lat, dn, bg);
        check(nd == 2, "R4 dirty count", nd, 2);
        check(dl[0] == 1, "R7 first dirty index", dl[0], 1);
        check(dl[1] == 2, "R7 second dirty index", dl[1], 2);
        check_mem("R2 halves exchanged on pages 1 and 2");
        check(dn == 1, "R9 start while busy ignored", dn, 1);
        check(bg == 0, "R8 busy until done", bg, 0);
    endtask

    task automatic t_resave;
        int nd, lat, dn, bg; int dl[8];
        run_op(1'b1, 4, 0, nd, dl, lat, dn, bg);
        run_op(1'b0, 4, 0, nd, dl, lat, dn, bg);
        check(nd == 0, "R5 bits overwritten by second save", nd, 0);
        phys_tab[2] = 32'h0000_2000 | BIT17;   // cleared bit now differs
        phys_tab[3] = 32'h0000_3000 | BIT17;   // outside shorter list
        model_swap(2);
        run_op(1'b0, 3, 0, nd, dl, lat, dn, bg);
        check(nd == 1 && dl[0] == 2, "R5 cleared bit detected", dl[0], 2);
        check_mem("R3 page past count untouched");
    endtask

    initial begin
        for (int p = 0; p < MAXP; p++) phys_tab[p] = 32'(p % 4) << 12;
        for (int i = 0; i < WORDS; i++) exp_mem[i] = pattern(i);
        init_mem = 1'b1;
        repeat (3) @(negedge clk);
        init_mem = 1'b0;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_no_record();
        t_zero();
        t_save_match();
        t_swap();
        t_resave();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Whole-run watchdog
    initial begin
        #900000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule